// File: doc/BRIEF.md
# Three-to-Seven Wraparound Counter

This block is a 3-bit synchronous up counter whose legal range is the five values three through seven. After seven it returns to three, so the values zero, one and two never appear while it runs normally. The return to three is a synchronous load of a constant through the next-state multiplexer. No flip-flop is preset or cleared outside the clock edge, so the count never passes through zero between edges.

The next state comes from a small controller that names one transition per clock. The transitions are T_HOLD (enable low), T_STEP (legal value three to six, so the incremented value is taken), T_WRAP (value seven, so three is loaded) and T_RECOVER (an illegal value zero, one or two, so three is loaded). The states are ST_ILL0, ST_ILL1 and ST_ILL2, which are illegal, and ST_V3 to ST_V7, which form the legal ring. A synchronous reset puts the register in ST_V3 and takes priority over every transition.

The block suits any place that needs a short repeating count whose lowest codes are reserved. The output comes straight from the state register.

Top module: `wrap3to7_counter`

## Requirements
- R1: With `rst` high at a rising edge, `count` reads 3 (binary 011) after that edge.
- R2: With `rst` low and `en` high, a value of 3, 4, 5 or 6 becomes that value plus one at the next rising edge.
- R3: With `rst` low and `en` high, a value of 7 becomes 3 at the next rising edge, and no other value appears in between.
- R4: With `rst` low and `en` low, `count` keeps its value at the rising edge. This includes 7, which does not wrap, and any illegal value.
- R5: If the register holds 0, 1 or 2, the first rising edge with `en` high and `rst` low loads 3.
- R6: Reset takes priority over enable. With both high, `count` reads 3 after the edge whatever it held before.
- R7: `count` changes only at a rising edge and stays steady for the rest of the clock period.
- R8: Once `count` holds a legal value (3 to 7), it never shows 0, 1 or 2 at a later edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock. All state changes happen on its rising edge. |
| rst | input | 1 | Synchronous reset, active high. Loads 3. |
| en | input | 1 | Count enable. Controls both the step and the wrap. |
| count | output | 3 | Present count, taken straight from the state register. |

## Verification
Two pairs of functions can land on the same edge. The first is a reset together with an enabled wrap from seven. The second is an enabled step together with recovery from an illegal value.

The bench drives both pairs as directed cases. It reaches seven and then raises reset and enable together. Separately, it starts the register in the all-zero illegal state and holds it there with enable low before enabling it. It then runs random mixes of reset and enable, which produce further collisions.

Each case is judged against a reference model in the bench. That model gives reset priority, then hold, then load-three for seven or an illegal value, then the increment. The bench also checks that the output has not moved by mid-cycle.

// File: rtl/wrap3to7_pkg.sv
package wrap3to7_pkg;

    localparam int CNT_W = 3;

    typedef enum logic [CNT_W-1:0] {
        ST_ILL0 = 3'd0,
        ST_ILL1 = 3'd1,
        ST_ILL2 = 3'd2,
        ST_V3   = 3'd3,
        ST_V4   = 3'd4,
        ST_V5   = 3'd5,
        ST_V6   = 3'd6,
        ST_V7   = 3'd7
    } cnt_state_t;

    typedef enum logic [1:0] {
        T_HOLD    = 2'd0,
        T_STEP    = 2'd1,
        T_WRAP    = 2'd2,
        T_RECOVER = 2'd3
    } cnt_trans_t;

    localparam cnt_state_t LOAD_STATE  = ST_V3;
    localparam cnt_state_t RESET_STATE = ST_V3;

endpackage

// File: rtl/wrap3to7_incr.sv
module wrap3to7_incr #(
    parameter int W = 3
) (
    input  logic [W-1:0] val_i,
    output logic [W-1:0] inc_o
);
    // A bit toggles when every bit below it is one.
    assign inc_o[0] = ~val_i[0];

    generate
        for (genvar b = 1; b < W; b++) begin : g_bit
            assign inc_o[b] = val_i[b] ^ (&val_i[b-1:0]);
        end
    endgenerate

endmodule

// File: rtl/wrap3to7_ctrl.sv
module wrap3to7_ctrl
    import wrap3to7_pkg::*;
(
    input  cnt_state_t cur_i,
    input  logic       en_i,
    output cnt_trans_t trans_o
);
    always_comb begin
        trans_o = T_HOLD;
        if (en_i) begin
            unique case (cur_i)
                ST_ILL0, ST_ILL1, ST_ILL2: trans_o = T_RECOVER;
                ST_V3, ST_V4, ST_V5, ST_V6: trans_o = T_STEP;
                ST_V7:                      trans_o = T_WRAP;
                default:                    trans_o = T_RECOVER;
            endcase
        end
    end

endmodule

// File: rtl/wrap3to7_mux.sv
module wrap3to7_mux
    import wrap3to7_pkg::*;
(
    input  cnt_trans_t       trans_i,
    input  cnt_state_t       cur_i,
    input  logic [CNT_W-1:0] inc_i,
    output cnt_state_t       nxt_o
);
    always_comb begin
        unique case (trans_i)
            T_HOLD:    nxt_o = cur_i;
            T_STEP:    nxt_o = cnt_state_t'(inc_i);
            T_WRAP:    nxt_o = LOAD_STATE;
            T_RECOVER: nxt_o = LOAD_STATE;
            default:   nxt_o = LOAD_STATE;
        endcase
    end

endmodule

// File: rtl/wrap3to7_state_reg.sv
module wrap3to7_state_reg
    import wrap3to7_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  cnt_state_t nxt_i,
    output cnt_state_t state_o
);
    cnt_state_t state_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= RESET_STATE;
        end else begin
            state_q <= nxt_i;
        end
    end

    assign state_o = state_q;

endmodule

// File: rtl/wrap3to7_counter.sv
module wrap3to7_counter
    import wrap3to7_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    output logic [CNT_W-1:0] count
);
    cnt_state_t       state;
    cnt_state_t       nxt;
    cnt_trans_t       trans;
    logic [CNT_W-1:0] inc;

    wrap3to7_incr #(.W(CNT_W)) u_incr (
        .val_i (state),
        .inc_o (inc)
    );

    wrap3to7_ctrl u_ctrl (
        .cur_i   (state),
        .en_i    (en),
        .trans_o (trans)
    );

    wrap3to7_mux u_mux (
        .trans_i (trans),
        .cur_i   (state),
        .inc_i   (inc),
        .nxt_o   (nxt)
    );

    wrap3to7_state_reg u_state_reg (
        .clk     (clk),
        .rst     (rst),
        .nxt_i   (nxt),
        .state_o (state)
    );

    always_comb begin
        count = state;
    end

endmodule

// File: rtl/wrap3to7_checker.sv
module wrap3to7_checker (
    input logic       clk,
    input logic       rst,
    input logic       en,
    input logic [2:0] count
);
    AST_RESET_LOADS_THREE: assert property (@(posedge clk)
        rst |=> count == 3'd3); // R1

    AST_STEP_UP: assert property (@(posedge clk) disable iff (rst)
        (en && count >= 3'd3 && count <= 3'd6) |=> count == $past(count) + 3'd1); // R2

    AST_WRAP_TO_THREE: assert property (@(posedge clk) disable iff (rst)
        (en && count == 3'd7) |=> count == 3'd3); // R3

    AST_HOLD_WHEN_IDLE: assert property (@(posedge clk) disable iff (rst)
        !en |=> $stable(count)); // R4

    AST_RECOVER_ILLEGAL: assert property (@(posedge clk) disable iff (rst)
        (en && count < 3'd3) |=> count == 3'd3); // R5

    AST_RESET_BEATS_EN: assert property (@(posedge clk)
        (rst && en) |=> count == 3'd3); // R6

    AST_STAYS_LEGAL: assert property (@(posedge clk)
        count >= 3'd3 |=> count >= 3'd3); // R8

endmodule

bind wrap3to7_counter wrap3to7_checker u_chk (
    .clk   (clk),
    .rst   (rst),
    .en    (en),
    .count (count)
);

// File: tb/wrap3to7_counter_bench.sv
`timescale 1ns/1ps
module wrap3to7_counter_bench;

    logic       clk = 1'b0;
    logic       rst = 1'b0;
    logic       en  = 1'b0;
    logic [2:0] count;
    logic [2:0] exp_cnt = 3'd0;
    int         n_chk = 0;
    int         n_bad = 0;
    bit         done  = 0;

    always #2.5 clk = ~clk;

    wrap3to7_counter u_wrap3to7_counter (
        .clk   (clk),
        .rst   (rst),
        .en    (en),
        .count (count)
    );

    function automatic logic [2:0] model(input logic [2:0] cur, input logic r, input logic e);
        if (r) return 3'd3;
        if (!e) return cur;
        if (cur == 3'd7 || cur < 3'd3) return 3'd3;
        return cur + 3'd1;
    endfunction

    task automatic check(input string req, input logic [2:0] act, input logic [2:0] want);
        n_chk++;
        if (act !== want) begin
            n_bad++;
            $display("FAIL %s: count=%0d expected=%0d at %0t", req, act, want, $time);
        end
    endtask

    task automatic cycle(input logic r, input logic e);
        string      tag;
        logic [2:0] prev;
        prev = exp_cnt;
        if (r) tag = e ? "R6" : "R1";
        else if (!e) tag = "R4";
        else if (prev == 3'd7) tag = "R3";
        else if (prev < 3'd3) tag = "R5";
        else tag = "R2";
        rst = r;
        en  = e;
        exp_cnt = model(prev, r, e);
        @(posedge clk);
        #1;
        check(tag, count, exp_cnt);
        if (!r && prev >= 3'd3 && count < 3'd3) check("R8", count, 3'd3);
        #2;
        check("R7", count, exp_cnt);
    endtask

    initial begin
        void'($urandom(32'd20240611));
        #1;
        // Illegal start value, placed before the first edge.
        force u_wrap3to7_counter.u_state_reg.state_q = wrap3to7_pkg::ST_ILL0;
        release u_wrap3to7_counter.u_state_reg.state_q;
        exp_cnt = 3'd0;
        cycle(1'b0, 1'b0);            // R4 hold on an illegal value
        cycle(1'b0, 1'b1);            // R5 recover to 3
        cycle(1'b1, 1'b0);            // R1 reset state
        for (int i = 0; i < 4; i++) cycle(1'b0, 1'b1); // R2 steps to 7
        cycle(1'b0, 1'b0);            // R4 hold at 7, no wrap
        cycle(1'b0, 1'b1);            // R3 wrap 7 -> 3
        for (int i = 0; i < 4; i++) cycle(1'b0, 1'b1);
        cycle(1'b1, 1'b1);            // R6 reset with enable at 7
        for (int i = 0; i < 400; i++) begin
            cycle(($urandom % 16) == 0, ($urandom % 4) != 0);
        end
        if (!done) begin
            done = 1;
            $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            done = 1;
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: count=%0d expected=%0d", count, exp_cnt);
            $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

endmodule